// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches three external interrupt pins and turns their activity into a single interrupt request for a processor core. Each pin first goes through a two-flop synchroniser. A per-source detector then looks for the trigger condition that software has chosen. When that condition occurs, the detector latches a flag. The flag is latched even when the source is masked. A request is raised only when three things are true together: the source's flag is set, its mask bit is set, and the global enable input is high.

When several sources are pending, a fixed-priority arbiter picks one. Source 0 is the highest priority and source 2 the lowest. The arbiter reports the winner as a vector index of 1, 2 or 3. The core acknowledges a source by pulsing `ack` with that index, which clears the flag. Software can also clear a flag by writing a one to its bit. Sources 0 and 1 have four sense modes. Source 2 has only two edge modes.

The flag of each source is a two-state machine with the states FLAG_IDLE and FLAG_HELD:
- FLAG_IDLE to FLAG_HELD (transition "set") happens when a trigger event occurs.
- FLAG_HELD to FLAG_IDLE (transition "clear") happens when an acknowledge or a write-one clear arrives and no new event occurs in the same cycle.
- In every other case the state holds.

Top module: `eis_top`

## Requirements
- R1: After reset, `irq_req` is 0 and `irq_vec` is 0. Reads of the control register (address 0), the mask register (address 1) and the flag register (address 2) all return 0x00.
- R2: Control bits [1:0] select the sense mode of source 0 and bits [3:2] select the mode of source 1. The codes are: 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge. The control register reads back bits [4:0] as written.
- R3: Control bit 4 selects the edge for source 2: 0 = falling edge, 1 = rising edge.
- R4: A pin edge becomes visible in the flag register after three rising clock edges. It is not visible after two.
- R5: A flag is set by its trigger event whether or not its mask bit is set. Flag bits sit at bit 6 (source 0), bit 7 (source 1) and bit 5 (source 2) of address 2.
- R6: A source requests only when its flag, its mask bit and `glob_en` are all 1. The mask bits sit at bit 6 (source 0), bit 7 (source 1) and bit 5 (source 2) of address 1. When `glob_en` is 0, `irq_req` is 0.
- R7: In low-level mode a source requests while its synchronised pin is low. Its flag is not set.
- R8: Priority is source 0, then source 1, then source 2. `irq_vec` is 1, 2 or 3 for the winning source, and 0 when no request is pending.
- R9: An `ack` pulse with `ack_vec` equal to i+1 clears the flag of source i on that clock edge.
- R10: Writing to address 2 clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R11: A trigger event in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 3 | External interrupt pins, bit i is source i |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 = control, 1 = mask, 2 = flag clear |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| glob_en | input | 1 | Global interrupt enable |
| ack | input | 1 | Acknowledge pulse from the core |
| ack_vec | input | 2 | Vector index being acknowledged |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 2 | Vector index of the winning source |

## Verification
The collision that matters is a new trigger event arriving on the same clock edge that an acknowledge or a write-one clear removes the flag. The bench provokes this directly. It raises a rising edge on pin 0, counts two clock edges so that the synchronised edge lines up with the next edge, and pulses `ack` for vector 1 exactly there. It then judges that the flag still reads as set. The random phase mixes pin toggles, clears and acknowledges of the current winner, so the same overlap recurs on every source. Each outcome is compared with a bench model of the flags derived from the requirements.

// File: rtl/eis_pkg.sv
package eis_pkg;
    localparam int NSRC = 3;
    localparam int VW   = 2;
    localparam int DW   = 8;
    localparam int AW   = 2;
    localparam int CW   = 5;

    localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [AW-1:0] ADDR_MASK = 2'd1;
    localparam logic [AW-1:0] ADDR_FLAG = 2'd2;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_t;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_HELD = 1'b1
    } flag_st_t;

    function automatic int src_bit(input int idx);
        case (idx)
            0:       return 6;
            1:       return 7;
            default: return 5;
        endcase
    endfunction
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
    parameter int   W       = 3,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= {W{RST_VAL}};
            q      <= {W{RST_VAL}};
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/eis_source.sv
module eis_source
    import eis_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_s,
    input  sense_t sense,
    input  logic   clr,
    input  logic   enable,
    output logic   evt,
    output logic   flag,
    output logic   pend
);
    logic     pin_prev;
    flag_st_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev <= IDLE_LVL;
        else        pin_prev <= pin_s;
    end

    always_comb begin
        unique case (sense)
            SNS_LOW:  evt = 1'b0;
            SNS_ANY:  evt = pin_s ^ pin_prev;
            SNS_FALL: evt = pin_prev & ~pin_s;
            SNS_RISE: evt = ~pin_prev & pin_s;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLAG_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            FLAG_IDLE: state_nxt = evt ? FLAG_HELD : FLAG_IDLE;
            FLAG_HELD: state_nxt = (clr && !evt) ? FLAG_IDLE : FLAG_HELD;
        endcase
    end

    always_comb begin
        flag = (state == FLAG_HELD);
        if (sense == SNS_LOW) pend = enable & ~pin_s;
        else                  pend = enable & flag;
    end
endmodule

// File: rtl/eis_prio.sv
module eis_prio #(
    parameter int N  = 3,
    parameter int VW = 2
) (
    input  logic [N-1:0]  pend,
    output logic          req,
    output logic [VW-1:0] vec
);
    always_comb begin
        vec = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) vec = VW'(i + 1);
        end
        req = |pend;
    end
endmodule

// File: rtl/eis_top.sv
module eis_top
    import eis_pkg::*;
#(
    parameter logic PIN_IDLE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NSRC-1:0] pin_in,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          glob_en,
    input  logic          ack,
    input  logic [VW-1:0] ack_vec,
    output logic          irq_req,
    output logic [VW-1:0] irq_vec
);
    logic [CW-1:0]   ctrl_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] pin_s;
    logic [NSRC-1:0] src_evt, src_flag, src_pend, src_clr;

    eis_sync #(.W(NSRC), .RST_VAL(PIN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL) ctrl_q <= wr_data[CW-1:0];
            if (wr_addr == ADDR_MASK) begin
                for (int k = 0; k < NSRC; k++) mask_q[k] <= wr_data[src_bit(k)];
            end
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        sense_t sense;
        if (i < 2) begin : g_full
            assign sense = sense_t'(ctrl_q[2*i +: 2]);
        end else begin : g_edge
            assign sense = ctrl_q[4] ? SNS_RISE : SNS_FALL;
        end

        assign src_clr[i] = (ack && (ack_vec == VW'(i + 1)))
                          || (wr_en && (wr_addr == ADDR_FLAG) && wr_data[src_bit(i)]);

        eis_source #(.IDLE_LVL(PIN_IDLE)) u_src (
            .clk(clk), .rst_n(rst_n), .pin_s(pin_s[i]), .sense(sense),
            .clr(src_clr[i]), .enable(mask_q[i] & glob_en),
            .evt(src_evt[i]), .flag(src_flag[i]), .pend(src_pend[i])
        );
    end

    eis_prio #(.N(NSRC), .VW(VW)) u_prio (
        .pend(src_pend), .req(irq_req), .vec(irq_vec)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL: rd_data[CW-1:0] = ctrl_q;
            ADDR_MASK: for (int k = 0; k < NSRC; k++) rd_data[src_bit(k)] = mask_q[k];
            ADDR_FLAG: for (int k = 0; k < NSRC; k++) rd_data[src_bit(k)] = src_flag[k];
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/eis_chk.sv
module eis_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       glob_en,
    input logic       irq_req,
    input logic [1:0] irq_vec,
    input logic [2:0] evt,
    input logic [2:0] flag,
    input logic [2:0] pend
);
    assert_req_needs_glob_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> !irq_req);

    assert_vec_when_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec != 2'd0));

    assert_vec_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vec == 2'd0));

    assert_prio_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend[0] |-> (irq_vec == 2'd1));

    assert_prio_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[1] && !pend[0]) |-> (irq_vec == 2'd2));

    assert_set_wins_s0_R11: assert property (@(posedge clk) disable iff (!rst_n)
        evt[0] |=> flag[0]);

    assert_set_wins_s1_R11: assert property (@(posedge clk) disable iff (!rst_n)
        evt[1] |=> flag[1]);

    assert_set_wins_s2_R11: assert property (@(posedge clk) disable iff (!rst_n)
        evt[2] |=> flag[2]);
endmodule

bind eis_top eis_chk u_chk (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .irq_req(irq_req),
    .irq_vec(irq_vec), .evt(src_evt), .flag(src_flag), .pend(src_pend)
);

// File: tb/sim_eis_top.sv
`timescale 1ns/1ps
module sim_eis_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pin = 3'b111;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       glob_en = 1'b0;
    logic       ack = 1'b0;
    logic [1:0] ack_vec = 2'd0;
    logic       irq_req;
    logic [1:0] irq_vec;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    eis_top u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .glob_en(glob_en),
        .ack(ack), .ack_vec(ack_vec), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    function automatic int fbit(input int i);
        return (i == 0) ? 6 : (i == 1) ? 7 : 5;
    endfunction

    // reference model built from the requirements
    logic [2:0] m_s1, m_s2, m_pv, m_flag, m_mask, m_e, m_c;
    logic [4:0] m_ctrl;

    function automatic logic [1:0] mode_of(input logic [4:0] c, input int i);
        if (i < 2) return c[2*i +: 2];
        return c[4] ? 2'b11 : 2'b10;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 3'b111; m_s2 = 3'b111; m_pv = 3'b111;
            m_flag = 3'b0; m_mask = 3'b0; m_ctrl = 5'b0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                case (mode_of(m_ctrl, i))
                    2'b01:   m_e[i] = m_s2[i] ^ m_pv[i];
                    2'b10:   m_e[i] = m_pv[i] & ~m_s2[i];
                    2'b11:   m_e[i] = ~m_pv[i] & m_s2[i];
                    default: m_e[i] = 1'b0;
                endcase
                m_c[i] = (ack && ack_vec == 2'(i + 1))
                       || (wr_en && wr_addr == 2'd2 && wr_data[fbit(i)]);
            end
            m_flag = m_e | (m_flag & ~m_c);
            if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data[4:0];
            if (wr_en && wr_addr == 2'd1) m_mask = {wr_data[5], wr_data[7], wr_data[6]};
            m_pv = m_s2; m_s2 = m_s1; m_s1 = pin;
        end
    end

    function automatic logic [2:0] exp_pend();
        logic [2:0] p;
        for (int i = 0; i < 3; i++)
            p[i] = glob_en & m_mask[i] &
                   ((mode_of(m_ctrl, i) == 2'b00) ? ~m_s2[i] : m_flag[i]);
        return p;
    endfunction

    function automatic logic [1:0] exp_vec(input logic [2:0] p);
        if (p[0]) return 2'd1;
        if (p[1]) return 2'd2;
        if (p[2]) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [7:0] exp_flag_byte();
        logic [7:0] b = 8'd0;
        for (int i = 0; i < 3; i++) b[fbit(i)] = m_flag[i];
        return b;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setpin(input int i, input logic v);
        @(negedge clk);
        pin[i] = v;
    endtask

    task automatic pulse_ack(input logic [1:0] v);
        @(negedge clk);
        ack = 1'b1; ack_vec = v;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic chk_irq(input string tag, input logic r, input logic [1:0] v);
        #0.5;
        chk({tag, " req"}, {7'd0, irq_req}, {7'd0, r});
        chk({tag, " vec"}, {6'd0, irq_vec}, {6'd0, v});
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'd1234));
        waitn(4);
        rst_n = 1'b1;
        waitn(1);

        // R1 reset state
        chk_irq("R1", 1'b0, 2'd0);
        rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
        rd(2'd1, d); chk("R1 mask", d, 8'h00);
        rd(2'd2, d); chk("R1 flag", d, 8'h00);

        // R2 control readback, falling mode on sources 0 and 1
        wr(2'd0, 8'h0A);
        rd(2'd0, d); chk("R2 ctrl readback", d, 8'h0A);

        // R4 latency and R5 flag set while masked
        setpin(0, 1'b0);
        waitn(2);
        rd(2'd2, d); chk("R4 not yet", d, 8'h00);
        waitn(1);
        rd(2'd2, d); chk("R4 R5 flag set masked", d, 8'h40);
        chk_irq("R5 masked no req", 1'b0, 2'd0);

        // R6 gating
        glob_en = 1'b1;
        wr(2'd1, 8'h40);
        rd(2'd1, d); chk("R6 mask readback", d, 8'h40);
        chk_irq("R6 enabled", 1'b1, 2'd1);
        glob_en = 1'b0;
        chk_irq("R6 glob off", 1'b0, 2'd0);
        glob_en = 1'b1;

        // R8 priority
        setpin(1, 1'b0);
        waitn(3);
        wr(2'd1, 8'hC0);
        rd(2'd2, d); chk("R8 both flags", d, 8'hC0);
        chk_irq("R8 source0 wins", 1'b1, 2'd1);

        // R9 acknowledge
        pulse_ack(2'd1);
        rd(2'd2, d); chk("R9 ack clears s0", d, 8'h80);
        chk_irq("R9 source1 next", 1'b1, 2'd2);

        // R10 write-one clear
        wr(2'd2, 8'h00);
        rd(2'd2, d); chk("R10 zero write no effect", d, 8'h80);
        wr(2'd2, 8'h80);
        rd(2'd2, d); chk("R10 one clears", d, 8'h00);
        chk_irq("R10 idle", 1'b0, 2'd0);

        // R3 source 2 edges
        setpin(2, 1'b0);
        waitn(3);
        wr(2'd1, 8'hE0);
        rd(2'd2, d); chk("R3 falling", d, 8'h20);
        chk_irq("R3 vec3", 1'b1, 2'd3);
        wr(2'd2, 8'h20);
        wr(2'd0, 8'h1A);
        setpin(2, 1'b1);
        waitn(3);
        rd(2'd2, d); chk("R3 rising", d, 8'h20);
        wr(2'd2, 8'h20);

        // R7 low level on source 0
        wr(2'd0, 8'h18);
        chk_irq("R7 level req", 1'b1, 2'd1);
        rd(2'd2, d); chk("R7 no flag", d, 8'h00);
        setpin(0, 1'b1);
        waitn(3);
        chk_irq("R7 released", 1'b0, 2'd0);

        // R2 any change on source 1
        wr(2'd0, 8'h14);
        setpin(1, 1'b1);
        waitn(3);
        rd(2'd2, d); chk("R2 any rise", d, 8'h80);
        chk_irq("R2 any vec", 1'b1, 2'd2);
        wr(2'd2, 8'h80);
        setpin(1, 1'b0);
        waitn(3);
        rd(2'd2, d); chk("R2 any fall", d, 8'h80);
        wr(2'd2, 8'h80);

        // R2 rising on source 0
        wr(2'd0, 8'h17);
        setpin(0, 1'b0);
        waitn(3);
        rd(2'd2, d); chk("R2 rise ignores fall", d, 8'h00);
        setpin(0, 1'b1);
        waitn(3);
        rd(2'd2, d); chk("R2 rise sets", d, 8'h40);
        wr(2'd2, 8'h40);

        // R11 event and acknowledge in the same cycle
        setpin(0, 1'b0);
        waitn(3);
        setpin(0, 1'b1);
        waitn(1);
        pulse_ack(2'd1);
        rd(2'd2, d); chk("R11 set wins", d, 8'h40);
        wr(2'd2, 8'h40);

        // random phase against the model (R5 R6 R8 R9 R10 R11)
        rd_addr = 2'd2;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            #0.5;
            begin
                logic [2:0] p;
                p = exp_pend();
                chk("R8 rnd req", {7'd0, irq_req}, {7'd0, |p});
                chk("R8 rnd vec", {6'd0, irq_vec}, {6'd0, exp_vec(p)});
                chk("R9 R10 R11 rnd flags", rd_data, exp_flag_byte());
            end
            wr_en = 1'b0;
            ack = 1'b0;
            for (int i = 0; i < 3; i++)
                if ($urandom_range(7) == 0) pin[i] = ~pin[i];
            if ($urandom_range(5) == 0) begin
                wr_en = 1'b1;
                wr_addr = 2'($urandom_range(3));
                wr_data = 8'($urandom);
            end
            if ($urandom_range(3) == 0) begin
                ack = 1'b1;
                ack_vec = ($urandom_range(1) == 0) ? irq_vec : 2'($urandom_range(3));
            end
            if ($urandom_range(15) == 0) glob_en = ~glob_en;
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule